// File: doc/BRIEF.md
# Processor Timer Unit with Decrementer and Status Flags

This block is the per-core timer unit of a processor. It keeps a 32-bit control word, a 32-bit status word, a down-counting decrementer and the reload value that the decrementer uses for automatic reload. Software writes and reads all four through a small register port. A write to the control word replaces the whole word. A write to the status word only clears the flags whose data bits are one.

The decrementer loses one on each time-base tick strobe. When it reaches zero it raises its status flag and, if auto-reload is enabled, starts again from the reload value. The watchdog and fixed-interval flags are set by event strobes from timers outside the block. Each of the three sources drives its own interrupt line. A line is high while its status flag and its enable bit are both set. The lines come from registers, so they change at the clock edge that updates the flag or the enable.

Top module: `tmr_unit`

## Requirements
- R1: Reset sets the control word, status word, decrementer and reload value to zero, and holds all three interrupt lines low.
- R2: A write to address 0 replaces all 32 control bits. A read of address 0 returns them unchanged.
- R3: A write to address 1 clears each status flag whose data bit is one and leaves every other flag unchanged. The status flags are: watchdog at bit 30, decrementer at bit 27, fixed-interval at bit 26. All other status bits read as zero.
- R4: A `wdog_evt` pulse sets status bit 30 and a `fit_evt` pulse sets status bit 26. When a set and a clear of the same flag happen in the same cycle, the set wins.
- R5: `irq_dec` equals status bit 27 AND control bit 26. `irq_wdog` equals status bit 30 AND control bit 27. `irq_fit` equals status bit 26 AND control bit 23. Each line changes at the same clock edge as the register bits it depends on.
- R6: On each cycle with `tb_tick` high and no write to the decrementer, a nonzero decrementer falls by one. Without a tick it holds its value.
- R7: A tick that takes the decrementer from one to zero sets status bit 27. With control bit 22 (auto-reload) clear, the count stays at zero and further ticks set no flag.
- R8: With control bit 22 set, the tick that would take the count from one to zero loads the reload value instead, and still sets status bit 27.
- R9: A write to address 2 loads the decrementer at the next clock edge. It wins over a tick in the same cycle, and it never sets the decrementer flag.
- R10: A write to address 3 stores the reload value. Reads of addresses 2 and 3 return the decrementer and the reload value, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Time-base tick strobe, one cycle per tick |
| wdog_evt | input | 1 | Watchdog period event, sets the watchdog flag |
| fit_evt | input | 1 | Fixed-interval period event, sets the fixed-interval flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 status, 2 decrementer, 3 reload |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as for writes |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq_dec | output | 1 | Decrementer interrupt |
| irq_wdog | output | 1 | Watchdog interrupt |
| irq_fit | output | 1 | Fixed-interval interrupt |

## Verification
The properties assume that each strobe lasts one clock, and that `wr_addr` and `wr_data` are stable whenever `wr_en` is high. They also assume that event pulses may coincide with status writes. The bench drives every input at the falling edge and holds it for exactly one cycle, so ticks, writes and events line up cycle by cycle the way the properties expect. The decrementer sweep uses small start values so that every tick count before, at and after expiry is reached. A few cycles are driven on purpose with a write and a tick, or a clear and a set, together, to exercise the priority rules.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // control word bit positions
   localparam int CTL_WDOG_IE = 27;
   localparam int CTL_DEC_IE  = 26;
   localparam int CTL_FIT_IE  = 23;
   localparam int CTL_ARE     = 22;
   // status word bit positions
   localparam int STS_WDOG    = 30;
   localparam int STS_DEC     = 27;
   localparam int STS_FIT     = 26;
   localparam logic [31:0] STS_IMPL = (32'd1 << STS_WDOG) | (32'd1 << STS_DEC) | (32'd1 << STS_FIT);
   // interrupt source indices
   localparam int SRC_DEC  = 0;
   localparam int SRC_WDOG = 1;
   localparam int SRC_FIT  = 2;
   localparam int NUM_SRC  = 3;

   typedef enum logic [1:0] {
      A_CTL = 2'd0,
      A_STS = 2'd1,
      A_DEC = 2'd2,
      A_RLD = 2'd3
   } tmr_addr_e;
endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q,
   output logic [W-1:0] q_nxt
);
   always_comb q_nxt = we ? wdata : q;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end
endmodule

// File: rtl/tmr_sts_reg.sv
module tmr_sts_reg #(
   parameter int          W         = 32,
   parameter logic [W-1:0] IMPL_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_we,
   input  logic [W-1:0] clr_data,
   input  logic [W-1:0] set_vec,
   output logic [W-1:0] q,
   output logic [W-1:0] q_nxt
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_flop
         logic bit_q;
         // set wins over a clear in the same cycle
         always_comb q_nxt[i] = set_vec[i] | (bit_q & ~(clr_we & clr_data[i]));
         always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= q_nxt[i];
         end
         assign q[i] = bit_q;
      end else begin : g_tie
         assign q_nxt[i] = 1'b0;
         assign q[i]     = 1'b0;
      end
   end
endmodule

// File: rtl/tmr_decr.sv
module tmr_decr #(
   parameter int DEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld_we,
   input  logic [DEC_W-1:0] ld_data,
   input  logic             rld_we,
   input  logic [DEC_W-1:0] rld_data,
   input  logic             auto_rld,
   output logic [DEC_W-1:0] cnt,
   output logic [DEC_W-1:0] rld,
   output logic             expire
);
   localparam logic [DEC_W-1:0] ONE = DEC_W'(1);
   logic [DEC_W-1:0] cnt_nxt;

   always_comb expire = tick & ~ld_we & (cnt == ONE);

   always_comb begin
      if (ld_we)                 cnt_nxt = ld_data;
      else if (expire)           cnt_nxt = auto_rld ? rld : '0;
      else if (tick && cnt != 0) cnt_nxt = cnt - ONE;
      else                       cnt_nxt = cnt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         rld <= '0;
      end else begin
         cnt <= cnt_nxt;
         if (rld_we) rld <= rld_data;
      end
   end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sts_nxt,
   input  logic [N-1:0] en_nxt,
   output logic [N-1:0] irq
);
   for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n) irq[i] <= 1'b0;
         else        irq[i] <= sts_nxt[i] & en_nxt[i];
      end
   end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEC_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tb_tick,
   input  logic              wdog_evt,
   input  logic              fit_evt,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_dec,
   output logic              irq_wdog,
   output logic              irq_fit
);
   if (DATA_W != 32) begin : g_bad_data_w
      $error("tmr_unit: DATA_W must be 32, field positions are fixed");
   end
   if (DEC_W < 2 || DEC_W > DATA_W) begin : g_bad_dec_w
      $error("tmr_unit: DEC_W must lie in 2..DATA_W");
   end

   logic              we_ctl, we_sts, we_dec, we_rld;
   logic [DATA_W-1:0] ctl_q, ctl_nxt, sts_q, sts_nxt, sts_set;
   logic [DEC_W-1:0]  dec_cnt, rld_q;
   logic              dec_expire;
   logic [DATA_W-1:0] dec_rd, rld_rd;
   logic [NUM_SRC-1:0] src_sts, src_en, irq_vec;

   always_comb begin
      we_ctl = wr_en && (wr_addr == A_CTL);
      we_sts = wr_en && (wr_addr == A_STS);
      we_dec = wr_en && (wr_addr == A_DEC);
      we_rld = wr_en && (wr_addr == A_RLD);
   end

   tmr_ctl_reg #(.W(DATA_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(we_ctl), .wdata(wr_data),
      .q(ctl_q), .q_nxt(ctl_nxt)
   );

   tmr_decr #(.DEC_W(DEC_W)) u_decr (
      .clk(clk), .rst_n(rst_n), .tick(tb_tick),
      .ld_we(we_dec), .ld_data(wr_data[DEC_W-1:0]),
      .rld_we(we_rld), .rld_data(wr_data[DEC_W-1:0]),
      .auto_rld(ctl_q[CTL_ARE]),
      .cnt(dec_cnt), .rld(rld_q), .expire(dec_expire)
   );

   always_comb begin
      sts_set           = '0;
      sts_set[STS_DEC]  = dec_expire;
      sts_set[STS_WDOG] = wdog_evt;
      sts_set[STS_FIT]  = fit_evt;
   end

   tmr_sts_reg #(.W(DATA_W), .IMPL_MASK(STS_IMPL)) u_sts (
      .clk(clk), .rst_n(rst_n), .clr_we(we_sts), .clr_data(wr_data),
      .set_vec(sts_set), .q(sts_q), .q_nxt(sts_nxt)
   );

   always_comb begin
      src_sts[SRC_DEC]  = sts_nxt[STS_DEC];
      src_sts[SRC_WDOG] = sts_nxt[STS_WDOG];
      src_sts[SRC_FIT]  = sts_nxt[STS_FIT];
      src_en[SRC_DEC]   = ctl_nxt[CTL_DEC_IE];
      src_en[SRC_WDOG]  = ctl_nxt[CTL_WDOG_IE];
      src_en[SRC_FIT]   = ctl_nxt[CTL_FIT_IE];
   end

   tmr_irq #(.N(NUM_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .sts_nxt(src_sts), .en_nxt(src_en), .irq(irq_vec)
   );

   assign irq_dec  = irq_vec[SRC_DEC];
   assign irq_wdog = irq_vec[SRC_WDOG];
   assign irq_fit  = irq_vec[SRC_FIT];

   if (DEC_W < DATA_W) begin : g_ext
      assign dec_rd = {{(DATA_W-DEC_W){1'b0}}, dec_cnt};
      assign rld_rd = {{(DATA_W-DEC_W){1'b0}}, rld_q};
   end else begin : g_full
      assign dec_rd = dec_cnt;
      assign rld_rd = rld_q;
   end

   always_comb begin
      unique case (rd_addr)
         A_CTL:   rd_data = ctl_q;
         A_STS:   rd_data = sts_q;
         A_DEC:   rd_data = dec_rd;
         default: rd_data = rld_rd;
      endcase
   end
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk
   import tmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEC_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tb_tick,
   input logic              wdog_evt,
   input logic              fit_evt,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] ctl_q,
   input logic [DATA_W-1:0] sts_q,
   input logic [DEC_W-1:0]  dec_cnt,
   input logic [DEC_W-1:0]  rld_q,
   input logic              irq_dec,
   input logic              irq_wdog,
   input logic              irq_fit
);
   logic dec_wr;
   assign dec_wr = wr_en && (wr_addr == 2'd2);

   assert_fit_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1 && wr_data[STS_FIT] && !fit_evt) |=> !sts_q[STS_FIT]);

   assert_wdog_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_evt |=> sts_q[STS_WDOG]);

   assert_irq_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_dec == (sts_q[STS_DEC] && ctl_q[CTL_DEC_IE]));

   assert_irq_wdog_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_wdog == (sts_q[STS_WDOG] && ctl_q[CTL_WDOG_IE]));

   assert_irq_fit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fit == (sts_q[STS_FIT] && ctl_q[CTL_FIT_IE]));

   assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_tick && !dec_wr && dec_cnt > DEC_W'(1)) |=> dec_cnt == $past(dec_cnt) - DEC_W'(1));

   assert_stop_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_tick && !dec_wr && dec_cnt == '0) |=> dec_cnt == '0);

   assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_tick && !dec_wr && dec_cnt == DEC_W'(1) && ctl_q[CTL_ARE])
      |=> (dec_cnt == $past(rld_q) && sts_q[STS_DEC]));

   assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dec_wr |=> dec_cnt == $past(wr_data[DEC_W-1:0]));
endmodule

bind tmr_unit tmr_unit_chk #(.DATA_W(DATA_W), .DEC_W(DEC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .wdog_evt(wdog_evt), .fit_evt(fit_evt),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .ctl_q(ctl_q), .sts_q(sts_q), .dec_cnt(dec_cnt), .rld_q(rld_q),
   .irq_dec(irq_dec), .irq_wdog(irq_wdog), .irq_fit(irq_fit)
);

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tb_tick = 1'b0, wdog_evt = 1'b0, fit_evt = 1'b0, wr_en = 1'b0;
   logic [1:0]  wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0, rd_data;
   logic        irq_dec, irq_wdog, irq_fit;
   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit done = 0;

   tmr_unit i_tmr_unit (
      .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .wdog_evt(wdog_evt), .fit_evt(fit_evt),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_dec(irq_dec), .irq_wdog(irq_wdog), .irq_fit(irq_fit)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic tick();
      @(negedge clk); tb_tick = 1'b1;
      @(negedge clk); tb_tick = 1'b0;
   endtask

   initial begin
      while (!done) begin
         @(posedge clk); cyc++;
         if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] v;
      int c;
      logic exp_dis;
      int rl [4] = '{0, 1, 4, 9};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R1 reg", v, 0); end
      check("R1 irq", {irq_dec, irq_wdog, irq_fit}, 0);
      // R2 control replace
      wr(2'd0, 32'hA5C3_0F0F); rd(2'd0, v); check("R2 ctl", v, 32'hA5C3_0F0F);
      wr(2'd0, 32'h0000_0000); rd(2'd0, v); check("R2 ctl zero", v, 0);
      // R4 events set flags
      @(negedge clk); wdog_evt = 1; fit_evt = 1;
      @(negedge clk); wdog_evt = 0; fit_evt = 0;
      rd(2'd1, v); check("R4 set", v, 32'h4400_0000);
      check("R5 no enable", {irq_dec, irq_wdog, irq_fit}, 0);
      wr(2'd0, 32'h0880_0000);
      check("R5 wdog irq", irq_wdog, 1); check("R5 fit irq", irq_fit, 1);
      // R3 clear only written ones
      wr(2'd1, 32'h4000_0000); rd(2'd1, v); check("R3 w1c", v, 32'h0400_0000);
      check("R5 wdog drop", irq_wdog, 0); check("R5 fit hold", irq_fit, 1);
      wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, v); check("R3 clear all", v, 0);
      check("R5 fit drop", irq_fit, 0);
      // R4 set beats clear
      @(negedge clk); wr_en = 1; wr_addr = 2'd1; wr_data = 32'hFFFF_FFFF; wdog_evt = 1;
      @(negedge clk); wr_en = 0; wdog_evt = 0;
      rd(2'd1, v); check("R4 set wins", v, 32'h4000_0000);
      wr(2'd1, 32'hFFFF_FFFF);
      // R6 R7 sweep, auto-reload off, decrementer irq enabled
      wr(2'd0, 32'h0400_0000);
      for (int n = 1; n <= 6; n++) begin
         for (int k = 0; k <= n + 2; k++) begin
            wr(2'd1, 32'hFFFF_FFFF);
            wr(2'd2, 32'(n));
            for (int t = 0; t < k; t++) tick();
            rd(2'd2, v); check("R6 R7 count", v, (k >= n) ? 0 : 32'(n - k));
            rd(2'd1, v); check("R7 flag", v, (k >= n) ? 32'h0800_0000 : 0);
            check("R5 dec irq", irq_dec, (k >= n) ? 1 : 0);
         end
      end
      // R6 hold without tick
      wr(2'd2, 32'd7); repeat (5) @(negedge clk);
      rd(2'd2, v); check("R6 hold", v, 7);
      // R8 auto-reload, R10 reload readback
      wr(2'd0, 32'h0440_0000);
      foreach (rl[i]) begin
         wr(2'd3, 32'(rl[i])); rd(2'd3, v); check("R10 reload rd", v, 32'(rl[i]));
         wr(2'd1, 32'hFFFF_FFFF);
         wr(2'd2, 32'd2);
         c = 2; exp_dis = 0;
         for (int t = 0; t < 12; t++) begin
            tick();
            if (c == 1) begin c = rl[i]; exp_dis = 1; end
            else if (c > 0) c--;
            rd(2'd2, v); check("R8 count", v, 32'(c));
            check("R8 irq", irq_dec, 32'(exp_dis));
         end
      end
      // R9 write beats tick, no flag from write
      wr(2'd0, 32'h0400_0000);
      wr(2'd1, 32'hFFFF_FFFF);
      wr(2'd2, 32'd1);
      @(negedge clk); wr_en = 1; wr_addr = 2'd2; wr_data = 32'd9; tb_tick = 1;
      @(negedge clk); wr_en = 0; tb_tick = 0;
      rd(2'd2, v); check("R9 write wins", v, 9);
      rd(2'd1, v); check("R9 no flag", v, 0);
      wr(2'd2, 32'd0); rd(2'd1, v); check("R9 zero write no flag", v, 0);
      // R1 reset mid-run
      wr(2'd2, 32'd33); wr(2'd3, 32'd5);
      @(negedge clk); fit_evt = 1; @(negedge clk); fit_evt = 0;
      @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
      for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R1 re-reset", v, 0); end
      check("R1 irq re-reset", {irq_dec, irq_wdog, irq_fit}, 0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule